// File: doc/BRIEF.md
# LPDDR2 Power-Up Initialization Sequencer

This block sits inside a low-power DDR2 memory controller and takes the attached device from power-on to normal operation. A one-cycle `start` pulse begins a run. The sequencer first strobes two configuration loads: the low-power and calibration-timing settings, then the memory type, configuration and timing sets. It then walks a fixed list of device commands. The list opens with two no-operation commands separated by a short pause. A long settling pause follows, then a device reset, then a ZQ initialization calibration and a series of mode-register writes. An input-buffer window opens partway through the list, and the run ends with the switch to normal mode.

Each command goes out as an opcode plus an 8-bit mode-register address with a valid strobe. The command is held until the memory-side logic acknowledges it with `cmd_ready`, which stands for the dummy access that confirms each command. The minimum pauses are counted in clock cycles. Each is derived from a clock-frequency parameter and rounded up. After the normal-mode command, the block strobes the refresh-count load and then the calibration and MR4-read period load. It then drops `busy` and raises `done`.

Top module: `lp2_bringup_seq`

## Requirements
- R1: While reset is applied and after its release, `busy`, `done`, `cmd_valid`, `ibuf_en`, `load_en` and `zq_type` are all 0 until a start is seen.
- R2: A `start` seen while idle sets `busy` on the next cycle. Before the first command is presented, `load_en` pulses exactly twice: first with `load_sel` = 0 (low-power and calibration timing), then with `load_sel` = 1 (type, configuration and timings).
- R3: Exactly 14 commands are accepted, in this order, as (opcode, address): NOP, NOP, MRW 63, MRW 10, MRW 1, MRW 2, MRW 3, MRW 16, NOP, MRW 5, MRW 6, MRW 8, MRW 0, NORMAL. The opcode codes are NORMAL = 0, NOP = 1 and MRW = 7. The address is 0 for NOP and NORMAL.
- R4: Once `cmd_valid` is high it stays high, with `cmd_op` and `cmd_mra` unchanged, until a cycle in which `cmd_ready` is high.
- R5: At least ceil(100 × CLK_MHZ / 1000) cycles (13 at 125 MHz) lie strictly between the cycle the first NOP is accepted and the first cycle the second NOP is presented.
- R6: At least ceil(200000 × CLK_MHZ / 1000) cycles (25000 at 125 MHz) lie strictly between acceptance of the second NOP and the first cycle of the reset command (MRW 63).
- R7: At least ceil(1000 × CLK_MHZ / 1000) cycles (125 at 125 MHz) lie strictly between acceptance of MRW 63 and the first cycle of MRW 10.
- R8: `zq_type` is 0 (none) before MRW 10. It is 1 (reset/init) when MRW 10 is accepted, and 2 (short) when every later command is accepted.
- R9: `ibuf_en` is high when the NOP after MRW 16, and every command after it up to and including NORMAL, is accepted. It is low when each earlier command is accepted and during every `load_en` pulse.
- R10: After NORMAL is accepted, `load_en` pulses with `load_sel` = 2 (refresh count) and then with `load_sel` = 3 (calibration/MR4 period). `done` then rises as `busy` falls, and `done` stays high until a new start or `seq_clr`.
- R11: A `start` pulse while `busy` is high is ignored: the run continues and no configuration load repeats.
- R12: `seq_clr` returns the block to idle on the next cycle, with `busy`, `done`, `cmd_valid`, `ibuf_en` and `zq_type` all 0. A later start then performs a complete run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an initialization run (ignored while busy) |
| seq_clr | input | 1 | Synchronous return to idle |
| cmd_ready | input | 1 | Command acknowledge from the memory side |
| cmd_valid | output | 1 | Command presented |
| cmd_op | output | 3 | Command opcode: 0 normal, 1 no-operation, 7 mode-register write |
| cmd_mra | output | 8 | Mode-register address for opcode 7 |
| zq_type | output | 2 | ZQ calibration type: 0 none, 1 reset/init, 2 short |
| ibuf_en | output | 1 | Input-buffer enable |
| load_en | output | 1 | One-cycle configuration load strobe |
| load_sel | output | 2 | Load target: 0 low-power/cal timing, 1 type/config/timings, 2 refresh, 3 cal/MR4 period |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed |

## Verification
The hardest situations to reach from the ports are a clear that lands while the input-buffer window is open and the ZQ type is already short, and a stray start that arrives in the middle of the 25000-cycle settling pause. The bench reaches the first by following accepted commands until the tenth has gone through, then pulsing `seq_clr` with an acknowledge still pending, and finally running a full sequence from scratch. It reaches the second by pulsing `start` a few hundred cycles into a run. The acknowledge latency is swept from zero to three cycles across runs, so back-to-back mode-register writes are covered both with and without stall cycles.

// File: rtl/lp2_init_pkg.sv
package lp2_init_pkg;

  localparam int MRA_W = 8;
  localparam int OP_W  = 3;

  localparam logic [OP_W-1:0] OP_NORMAL = 3'd0;
  localparam logic [OP_W-1:0] OP_NOP    = 3'd1;
  localparam logic [OP_W-1:0] OP_MRW    = 3'd7;

  localparam logic [1:0] ZQ_NONE  = 2'd0;
  localparam logic [1:0] ZQ_INIT  = 2'd1;
  localparam logic [1:0] ZQ_SHORT = 2'd2;

  localparam logic [1:0] LD_LOWPWR  = 2'd0;
  localparam logic [1:0] LD_CONFIG  = 2'd1;
  localparam logic [1:0] LD_REFRESH = 2'd2;
  localparam logic [1:0] LD_CALPER  = 2'd3;

  localparam logic [1:0] GAP_SHORT = 2'd0;
  localparam logic [1:0] GAP_LONG  = 2'd1;
  localparam logic [1:0] GAP_RESET = 2'd2;

  localparam int STEP_COUNT = 25;
  localparam int STEP_W     = $clog2(STEP_COUNT);

  typedef enum logic [2:0] {K_LOAD, K_CMD, K_WAIT, K_IBUF, K_ZQ} step_kind_e;

  typedef struct packed {
    step_kind_e       kind;
    logic [OP_W-1:0]  op;
    logic [MRA_W-1:0] mra;
    logic [1:0]       arg;
  } step_t;

  function automatic step_t mk(step_kind_e k, logic [OP_W-1:0] o,
                               logic [MRA_W-1:0] a, logic [1:0] g);
    step_t s;
    s.kind = k;
    s.op   = o;
    s.mra  = a;
    s.arg  = g;
    return s;
  endfunction

  // Bring-up program; the order of entries is the device protocol.
  function automatic step_t step_at(logic [STEP_W-1:0] idx);
    case (idx)
      5'd0:    step_at = mk(K_LOAD, OP_NOP, 8'd0, LD_LOWPWR);
      5'd1:    step_at = mk(K_LOAD, OP_NOP, 8'd0, LD_CONFIG);
      5'd2:    step_at = mk(K_CMD,  OP_NOP, 8'd0, 2'd0);
      5'd3:    step_at = mk(K_WAIT, OP_NOP, 8'd0, GAP_SHORT);
      5'd4:    step_at = mk(K_CMD,  OP_NOP, 8'd0, 2'd0);
      5'd5:    step_at = mk(K_WAIT, OP_NOP, 8'd0, GAP_LONG);
      5'd6:    step_at = mk(K_CMD,  OP_MRW, 8'd63, 2'd0);
      5'd7:    step_at = mk(K_WAIT, OP_NOP, 8'd0, GAP_RESET);
      5'd8:    step_at = mk(K_ZQ,   OP_NOP, 8'd0, ZQ_INIT);
      5'd9:    step_at = mk(K_CMD,  OP_MRW, 8'd10, 2'd0);
      5'd10:   step_at = mk(K_ZQ,   OP_NOP, 8'd0, ZQ_SHORT);
      5'd11:   step_at = mk(K_CMD,  OP_MRW, 8'd1, 2'd0);
      5'd12:   step_at = mk(K_CMD,  OP_MRW, 8'd2, 2'd0);
      5'd13:   step_at = mk(K_CMD,  OP_MRW, 8'd3, 2'd0);
      5'd14:   step_at = mk(K_CMD,  OP_MRW, 8'd16, 2'd0);
      5'd15:   step_at = mk(K_IBUF, OP_NOP, 8'd0, 2'd1);
      5'd16:   step_at = mk(K_CMD,  OP_NOP, 8'd0, 2'd0);
      5'd17:   step_at = mk(K_CMD,  OP_MRW, 8'd5, 2'd0);
      5'd18:   step_at = mk(K_CMD,  OP_MRW, 8'd6, 2'd0);
      5'd19:   step_at = mk(K_CMD,  OP_MRW, 8'd8, 2'd0);
      5'd20:   step_at = mk(K_CMD,  OP_MRW, 8'd0, 2'd0);
      5'd21:   step_at = mk(K_CMD,  OP_NORMAL, 8'd0, 2'd0);
      5'd22:   step_at = mk(K_IBUF, OP_NOP, 8'd0, 2'd0);
      5'd23:   step_at = mk(K_LOAD, OP_NOP, 8'd0, LD_REFRESH);
      5'd24:   step_at = mk(K_LOAD, OP_NOP, 8'd0, LD_CALPER);
      default: step_at = mk(K_LOAD, OP_NOP, 8'd0, LD_CALPER);
    endcase
  endfunction

endpackage

// File: rtl/lp2_step_rom.sv
module lp2_step_rom
  import lp2_init_pkg::*;
(
  input  logic [STEP_W-1:0] step_idx,
  output step_t             step
);

  assign step = step_at(step_idx);

endmodule

// File: rtl/lp2_gap_timer.sv
module lp2_gap_timer #(
  parameter int unsigned N_SHORT = 13,
  parameter int unsigned N_LONG  = 25000,
  parameter int unsigned N_RESET = 125,
  localparam int unsigned N_MAX  = (N_SHORT > N_LONG) ?
                                   ((N_SHORT > N_RESET) ? N_SHORT : N_RESET) :
                                   ((N_LONG  > N_RESET) ? N_LONG  : N_RESET),
  localparam int CW = $clog2(N_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       expire
);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          cnt_en;

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(N_SHORT);
      2'd1:    lim = CW'(N_LONG);
      default: lim = CW'(N_RESET);
    endcase
  end

  assign expire = en && (cnt_q == lim - 1'b1);
  assign cnt_en = en || (cnt_q != '0);

  always_comb begin
    if (!en || expire) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lp2_bringup_seq.sv
module lp2_bringup_seq
  import lp2_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 125,
  parameter int unsigned T_PAUSE_NS  = 100,
  parameter int unsigned T_SETTLE_NS = 200000,
  parameter int unsigned T_RESET_NS  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             seq_clr,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic [OP_W-1:0]  cmd_op,
  output logic [MRA_W-1:0] cmd_mra,
  output logic [1:0]       zq_type,
  output logic             ibuf_en,
  output logic             load_en,
  output logic [1:0]       load_sel,
  output logic             busy,
  output logic             done
);

  localparam int unsigned N_PAUSE  = (T_PAUSE_NS  * CLK_MHZ + 999) / 1000;
  localparam int unsigned N_SETTLE = (T_SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned N_RESET  = (T_RESET_NS  * CLK_MHZ + 999) / 1000;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_COUNT - 1);

  // Reset synchroniser: asserts asynchronously, releases on clk.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic              run_q, run_d, done_q, done_d, ibuf_q, ibuf_d;
  logic [1:0]        zq_q, zq_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              advance, gap_done, seq_en;
  step_t             cur;

  lp2_step_rom u_rom (
    .step_idx (step_q),
    .step     (cur)
  );

  lp2_gap_timer #(
    .N_SHORT (N_PAUSE),
    .N_LONG  (N_SETTLE),
    .N_RESET (N_RESET)
  ) u_gap (
    .clk    (clk),
    .rst_n  (rst_sync),
    .en     (run_q && cur.kind == K_WAIT),
    .sel    (cur.arg),
    .expire (gap_done)
  );

  always_comb begin
    run_d   = run_q;
    done_d  = done_q;
    step_d  = step_q;
    ibuf_d  = ibuf_q;
    zq_d    = zq_q;
    advance = 1'b0;
    if (seq_clr) begin
      run_d  = 1'b0;
      done_d = 1'b0;
      step_d = '0;
      ibuf_d = 1'b0;
      zq_d   = ZQ_NONE;
    end else if (!run_q) begin
      if (start) begin
        run_d  = 1'b1;
        done_d = 1'b0;
        step_d = '0;
        ibuf_d = 1'b0;
        zq_d   = ZQ_NONE;
      end
    end else begin
      case (cur.kind)
        K_LOAD:  advance = 1'b1;
        K_CMD:   advance = cmd_ready;
        K_WAIT:  advance = gap_done;
        K_IBUF:  begin advance = 1'b1; ibuf_d = cur.arg[0]; end
        K_ZQ:    begin advance = 1'b1; zq_d   = cur.arg;    end
        default: advance = 1'b0;
      endcase
      if (advance) begin
        if (step_q == LAST_STEP) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
    end
  end

  assign seq_en = seq_clr || start || run_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      ibuf_q <= 1'b0;
      zq_q   <= ZQ_NONE;
    end else if (seq_en) begin
      run_q  <= run_d;
      done_q <= done_d;
      step_q <= step_d;
      ibuf_q <= ibuf_d;
      zq_q   <= zq_d;
    end
  end

  assign cmd_valid = run_q && (cur.kind == K_CMD);
  assign cmd_op    = cmd_valid ? cur.op  : '0;
  assign cmd_mra   = (cmd_valid && cur.op == OP_MRW) ? cur.mra : '0;
  assign load_en   = run_q && (cur.kind == K_LOAD);
  assign load_sel  = load_en ? cur.arg : '0;
  assign zq_type   = zq_q;
  assign ibuf_en   = ibuf_q;
  assign busy      = run_q;
  assign done      = done_q;

endmodule

// File: rtl/lp2_bringup_sva.sv
module lp2_bringup_sva
  import lp2_init_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             seq_clr,
  input logic             cmd_ready,
  input logic             cmd_valid,
  input logic [OP_W-1:0]  cmd_op,
  input logic [MRA_W-1:0] cmd_mra,
  input logic [1:0]       zq_type,
  input logic             ibuf_en,
  input logic             load_en,
  input logic [1:0]       load_sel,
  input logic             busy,
  input logic             done
);

  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !seq_clr |=> cmd_valid && $stable(cmd_op) && $stable(cmd_mra));

  a_r3_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  a_r8_zq_init_on_mr10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_MRW && cmd_mra == 8'd10 |-> zq_type == ZQ_INIT);

  a_r9_ibuf_off_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !ibuf_en);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !seq_clr && !start |=> done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !seq_clr |=> busy || done);

  a_r12_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> !busy && !done && !cmd_valid && !ibuf_en && zq_type == ZQ_NONE);

  a_r2_load_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |-> load_sel == 2'd0);

endmodule

bind lp2_bringup_seq lp2_bringup_sva u_sva (.*);

// File: tb/tb_lp2_bringup_seq.sv
module tb_lp2_bringup_seq;

  localparam int CLK_MHZ = 125;
  localparam int GAP_PAUSE  = (100 * CLK_MHZ + 999) / 1000;
  localparam int GAP_SETTLE = (200000 * CLK_MHZ + 999) / 1000;
  localparam int GAP_RESET  = (1000 * CLK_MHZ + 999) / 1000;

  logic       clk, rst_n, start, seq_clr, cmd_ready;
  logic       cmd_valid, ibuf_en, load_en, busy, done;
  logic [2:0] cmd_op;
  logic [7:0] cmd_mra;
  logic [1:0] zq_type, load_sel;

  lp2_bringup_seq #(.CLK_MHZ(CLK_MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_clr(seq_clr),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mra(cmd_mra), .zq_type(zq_type), .ibuf_en(ibuf_en),
    .load_en(load_en), .load_sel(load_sel), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int idx = 0, load_cnt = 0, last_hs = 0, lat = 0, wcnt = 0;
  bit hs_pend = 0, prev_hs = 0, prev_valid = 0, prev_done = 0;
  bit clr_req = 0, clr_chk = 0;
  logic [2:0] prev_op;
  logic [7:0] prev_mra;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_op(int i);
    case (i)
      0, 1, 8: return 1;
      13:      return 0;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_mra(int i);
    case (i)
      2: return 63;  3: return 10; 4: return 1;  5: return 2;
      6: return 3;   7: return 16; 9: return 5;  10: return 6;
      11: return 8;  default: return 0;
    endcase
  endfunction

  // Acknowledge driver and protocol monitor, one place at the falling edge.
  always @(negedge clk) begin
    if (clr_chk) begin
      clr_chk = 0;
      chk(!busy && !done && !cmd_valid && !ibuf_en && zq_type == 2'd0,
          "R12 idle after clear", {busy, done, cmd_valid, ibuf_en, zq_type}, 0);
    end
    if (clr_req) begin
      clr_req = 0; clr_chk = 1; seq_clr = 1'b1;
      cmd_ready = 1'b0; hs_pend = 0; wcnt = 0;
    end else begin
      seq_clr = 1'b0;
      if (hs_pend) begin cmd_ready = 1'b0; wcnt = 0; hs_pend = 0; end
      if (prev_valid && !prev_hs)
        chk(cmd_valid && cmd_op == prev_op && cmd_mra == prev_mra,
            "R4 hold until ready", {cmd_valid, cmd_op, cmd_mra}, {1'b1, prev_op, prev_mra});
      if (cmd_valid && (!prev_valid || prev_hs)) begin
        if (idx == 1) chk(cyc - last_hs - 1 >= GAP_PAUSE,  "R5 pause gap",  cyc - last_hs - 1, GAP_PAUSE);
        if (idx == 2) chk(cyc - last_hs - 1 >= GAP_SETTLE, "R6 settle gap", cyc - last_hs - 1, GAP_SETTLE);
        if (idx == 3) chk(cyc - last_hs - 1 >= GAP_RESET,  "R7 reset gap",  cyc - last_hs - 1, GAP_RESET);
      end
      if (cmd_valid && !cmd_ready) begin
        if (wcnt >= lat) cmd_ready = 1'b1; else wcnt++;
      end
      prev_hs = 0;
      if (cmd_valid && cmd_ready) begin
        chk(idx < 14 && int'(cmd_op) == exp_op(idx) && int'(cmd_mra) == exp_mra(idx),
            "R3 command order", {cmd_op, cmd_mra}, {exp_op(idx)[2:0], exp_mra(idx)[7:0]});
        chk(int'(zq_type) == ((idx < 3) ? 0 : (idx == 3) ? 1 : 2),
            "R8 zq type", zq_type, (idx < 3) ? 0 : (idx == 3) ? 1 : 2);
        chk(ibuf_en == (idx >= 8 && idx <= 13), "R9 ibuf window", ibuf_en, (idx >= 8 && idx <= 13));
        hs_pend = 1; prev_hs = 1; last_hs = cyc; idx++;
      end
      if (load_en) begin
        chk(int'(load_sel) == load_cnt && (load_cnt < 2 ? idx == 0 : idx == 14),
            (load_cnt < 2) ? "R2 initial load order" : "R10 final load order", load_sel, load_cnt);
        chk(!ibuf_en, "R9 ibuf off at load", ibuf_en, 0);
        load_cnt++;
      end
      if (done && !prev_done)
        chk(!busy && load_cnt == 4 && idx == 14, "R10 done after final loads",
            {busy, 4'(load_cnt), 4'(idx)}, {1'b0, 4'd4, 4'd14});
    end
    prev_valid = cmd_valid; prev_op = cmd_op; prev_mra = cmd_mra; prev_done = done;
  end

  task automatic reset_trackers(int l);
    lat = l; idx = 0; load_cnt = 0; last_hs = cyc;
  endtask

  task automatic run_full(int l, bit poke);
    reset_trackers(l);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy, "R2 busy after start", busy, 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      chk(busy && load_cnt == 2 && idx == 2, "R11 start ignored while busy",
          {busy, 4'(load_cnt), 4'(idx)}, {1'b1, 4'd2, 4'd2});
    end
    for (int k = 0; k < 30000 && !done; k++) @(negedge clk);
    chk(done, "R10 run completes", done, 1);
    repeat (4) @(negedge clk);
    chk(done && !busy && !cmd_valid, "R10 done sticky", {done, busy, cmd_valid}, 3'b100);
    chk(idx == 14 && load_cnt == 4, "R3 command count", idx, 14);
  endtask

  task automatic finish_report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_report();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; seq_clr = 1'b0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !ibuf_en && !load_en && zq_type == 2'd0,
        "R1 state in reset", {busy, done, cmd_valid, ibuf_en, load_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !ibuf_en && !load_en && zq_type == 2'd0,
        "R1 idle after reset", {busy, done, cmd_valid, ibuf_en, load_en}, 0);

    run_full(0, 1'b0);
    run_full(3, 1'b1);

    // Clear inside the input-buffer window, acknowledge pending.
    reset_trackers(1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 30000 && idx < 10; k++) @(negedge clk);
    chk(idx == 10 && ibuf_en && zq_type == 2'd2, "R12 reached window before clear", idx, 10);
    clr_req = 1;
    repeat (6) @(negedge clk);
    chk(!busy && !done, "R12 stays idle", {busy, done}, 0);

    run_full(2, 1'b0);
    finish_report();
  end

endmodule